// File: doc/BRIEF.md
# Way-Partitioned Cache Victim Selector

This block decides which way of one cache set gets replaced when a fill needs room. It takes each way's tag state (valid, dirty, locked, use) and the identity of the requester. The requester is one of several cores or the shared class of hardware agents. Each requester has a way mask held in a small register file, and a 1 bit in a mask forbids that requester from evicting the way. The block returns the chosen way, whether that way holds dirty data, and a flag for the case where nothing may be evicted. In that case the fill bypasses allocation.

Masks and locks restrict only replacement. The hit search looks at every valid way for every requester. The block also computes the next use-bit vector after an access, so that the use-bit replacement policy does not saturate inside the ways a requester may use. It extracts the set index from a physical address, using 128-byte lines.

Requester identifiers 0 to CORES-1 select a core mask. Identifier CORES, and any value above it, selects the hardware-agent mask.

Top module: `way_victim_sel`

## Requirements
- R1: `set_idx` equals `addr` bits [7 +: log2(SETS)], because lines are 128 bytes.
- R2: All requester masks are 0 after reset. A write with `cfg_we` high stores `cfg_mask` into the mask chosen by `cfg_sel`, and `mask_rd` shows the mask chosen by `cfg_sel` from the next clock edge on.
- R3: A write whose mask is all ones is rejected. `cfg_err` is 1 for the cycle after the write edge and 0 after any other edge, and the stored mask keeps its old value.
- R4: A way whose bit is 1 in the mask of `req_id` is never reported as the victim. Cores and the hardware agents each use their own mask, so a way blocked in every mask is never evicted.
- R5: A way with `way_lock` set is never reported as the victim.
- R6: Among eligible ways (mask bit 0 and not locked), an invalid way is chosen first, lowest index winning.
- R7: If all eligible ways are valid, the lowest-index eligible way with `way_use` 0 is chosen.
- R8: If every eligible way has its use bit set, the lowest-index eligible way is chosen.
- R9: With no eligible way, `no_victim` is 1, `victim_way` is 0 and `victim_dirty` is 0.
- R10: `victim_dirty` is 1 exactly when a victim exists and that way is both valid and dirty.
- R11: `hit` is 1 when some way has both `way_valid` and `way_match`, and `hit_way` is the lowest such way, whatever the masks say.
- R12: `use_next` equals `way_use` with bit `acc_way` set. If that result has the use bit set in every eligible way of `req_id`, and at least one way is eligible, then `use_next` has only bit `acc_way` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Mask write strobe |
| cfg_sel | input | RID_W | Requester whose mask is written or read |
| cfg_mask | input | WAYS | Mask value to write, 1 = way protected |
| cfg_err | output | 1 | Rejected-write flag, one cycle |
| mask_rd | output | WAYS | Stored mask of `cfg_sel` |
| addr | input | ADDR_W | Physical address |
| set_idx | output | IDX_W | Set index of `addr` |
| req_id | input | RID_W | Requester of the current fill or access |
| way_valid | input | WAYS | Per-way valid flags |
| way_dirty | input | WAYS | Per-way dirty flags |
| way_lock | input | WAYS | Per-way lock flags |
| way_use | input | WAYS | Per-way use bits |
| way_match | input | WAYS | Per-way tag compare results |
| victim_way | output | VW | Chosen way |
| victim_dirty | output | 1 | Chosen way holds dirty data |
| no_victim | output | 1 | No way may be evicted |
| hit | output | 1 | Some valid way matches |
| hit_way | output | VW | Lowest matching valid way |
| acc_way | input | VW | Way touched by the current access |
| use_next | output | WAYS | Updated use bits |

## Verification
The bench checks several corner cases, each chosen because a specific design error would show up there.

- **Lock against invalid.** A locked invalid way sits below an unlocked invalid one. A design that tests validity before the lock would evict the locked line.
- **Masked invalid way.** An invalid way is masked for the requester. A picker that ignores the mask on the invalid-first path would hand a core a way it may not touch.
- **Rejected all-ones write.** The bench reads the mask back after the rejected write. A design that stores the value anyway would make that requester's fills stop allocating.
- **Use-bit reset.** The reset of the use bits is checked both just before and just at the point where every eligible way is full. Getting that boundary wrong leaves the policy stuck on one way.
- **Masked hit.** A hit in a masked way must still be reported. A design that filtered lookups by the mask would turn such hits into misses.

// File: rtl/vsel_pkg.sv
// Shared constants and helpers for the victim selector.
// Assumes byte addresses and a fixed 128-byte line.
package vsel_pkg;
    localparam int LINE_SHIFT = 7;

    // Map a requester identifier onto a mask slot; out-of-range ids use the agent slot.
    function automatic int req_slot(input int sel, input int cores);
        return (sel > cores) ? cores : sel;
    endfunction
endpackage

// File: rtl/vsel_mask_regs.sv
// Per-requester way mask registers.
// Holds one mask per core plus one shared by the hardware agents. Writes
// of an all-ones mask are refused and flagged. Two read ports: one for
// configuration readback, one for the requester of the current fill.
module vsel_mask_regs #(
    parameter int WAYS  = 8,
    parameter int CORES = 4,
    parameter int RID_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [RID_W-1:0] wsel,
    input  logic [WAYS-1:0]  wmask,
    output logic             err,
    output logic [WAYS-1:0]  rd_mask,
    input  logic [RID_W-1:0] qsel,
    output logic [WAYS-1:0]  q_mask
);
    import vsel_pkg::*;
    localparam int NREQ = CORES + 1;

    logic [WAYS-1:0] regs [NREQ];
    int wslot, qslot;

    // Slot decode for both ports.
    always_comb begin
        wslot = req_slot(int'(wsel), CORES);
        qslot = req_slot(int'(qsel), CORES);
    end

    // Mask storage with rejection of writes that leave no way free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREQ; i++) regs[i] <= '0;
            err <= 1'b0;
        end else begin
            err <= we && (&wmask);
            if (we && !(&wmask)) regs[wslot] <= wmask;
        end
    end

    // Read ports.
    assign rd_mask = regs[wslot];
    assign q_mask  = regs[qslot];
endmodule

// File: rtl/vsel_victim_pick.sv
// Replacement choice among eligible ways.
// Eligible means allowed by the mask and not locked. The order is: invalid
// ways, then ways with a clear use bit, then any eligible way, each by lowest
// index. Purely combinational; assumes WAYS >= 2.
module vsel_victim_pick #(
    parameter int WAYS = 8,
    parameter int VW   = $clog2(WAYS)
) (
    input  logic [WAYS-1:0] elig,
    input  logic [WAYS-1:0] valid,
    input  logic [WAYS-1:0] use_bits,
    input  logic [WAYS-1:0] dirty,
    output logic [VW-1:0]   way,
    output logic            way_dirty,
    output logic            none
);
    logic [WAYS-1:0] c_inv, c_cold;

    // Per-way candidate classes.
    genvar g;
    generate
        for (g = 0; g < WAYS; g++) begin : g_cls
            assign c_inv[g]  = elig[g] & ~valid[g];
            assign c_cold[g] = elig[g] & ~use_bits[g];
        end
    endgenerate

    // Lowest set bit of a way vector.
    function automatic logic [VW-1:0] first_set(input logic [WAYS-1:0] v);
        logic [VW-1:0] r;
        r = '0;
        for (int i = WAYS - 1; i >= 0; i--) if (v[i]) r = VW'(i);
        return r;
    endfunction

    // Priority selection and dirty report.
    always_comb begin
        none = ~|elig;
        if (|c_inv)       way = first_set(c_inv);
        else if (|c_cold) way = first_set(c_cold);
        else              way = first_set(elig);
        way_dirty = !none && valid[way] && dirty[way];
    end
endmodule

// File: rtl/vsel_use_update.sv
// Use-bit update after an access.
// Sets the accessed way's bit. When that fills every eligible way, all bits
// except the accessed one are cleared so the policy never saturates.
module vsel_use_update #(
    parameter int WAYS = 8,
    parameter int VW   = $clog2(WAYS)
) (
    input  logic [WAYS-1:0] use_bits,
    input  logic [WAYS-1:0] elig,
    input  logic [VW-1:0]   acc_way,
    output logic [WAYS-1:0] use_next
);
    logic [WAYS-1:0] acc_1h, merged;

    // Merge and wrap decision.
    always_comb begin
        acc_1h          = '0;
        acc_1h[acc_way] = 1'b1;
        merged          = use_bits | acc_1h;
        if ((|elig) && ((merged & elig) == elig)) use_next = acc_1h;
        else                                      use_next = merged;
    end
endmodule

// File: rtl/way_victim_sel.sv
// Way-partitioned victim selector, top level.
// Combines the mask registers, the victim picker and the use-bit updater,
// and adds the unrestricted hit search and the set-index extraction.
// Assumes the tag state inputs describe the set being accessed this cycle.
module way_victim_sel #(
    parameter int WAYS   = 8,
    parameter int CORES  = 4,
    parameter int SETS   = 256,
    parameter int ADDR_W = 32,
    localparam int VW    = $clog2(WAYS),
    localparam int RID_W = $clog2(CORES + 1),
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [RID_W-1:0]  cfg_sel,
    input  logic [WAYS-1:0]   cfg_mask,
    output logic              cfg_err,
    output logic [WAYS-1:0]   mask_rd,
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  set_idx,
    input  logic [RID_W-1:0]  req_id,
    input  logic [WAYS-1:0]   way_valid,
    input  logic [WAYS-1:0]   way_dirty,
    input  logic [WAYS-1:0]   way_lock,
    input  logic [WAYS-1:0]   way_use,
    input  logic [WAYS-1:0]   way_match,
    output logic [VW-1:0]     victim_way,
    output logic              victim_dirty,
    output logic              no_victim,
    output logic              hit,
    output logic [VW-1:0]     hit_way,
    input  logic [VW-1:0]     acc_way,
    output logic [WAYS-1:0]   use_next
);
    import vsel_pkg::*;

    logic [WAYS-1:0] sel_mask;
    logic [WAYS-1:0] elig;
    logic [WAYS-1:0] hit_vec;

    vsel_mask_regs #(.WAYS(WAYS), .CORES(CORES), .RID_W(RID_W)) u_masks (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wsel(cfg_sel), .wmask(cfg_mask),
        .err(cfg_err), .rd_mask(mask_rd), .qsel(req_id), .q_mask(sel_mask)
    );

    // Ways this requester may replace.
    assign elig = ~(sel_mask | way_lock);

    vsel_victim_pick #(.WAYS(WAYS), .VW(VW)) u_pick (
        .elig(elig), .valid(way_valid), .use_bits(way_use), .dirty(way_dirty),
        .way(victim_way), .way_dirty(victim_dirty), .none(no_victim)
    );

    vsel_use_update #(.WAYS(WAYS), .VW(VW)) u_use (
        .use_bits(way_use), .elig(elig), .acc_way(acc_way), .use_next(use_next)
    );

    // Set index from the address above the line offset.
    assign set_idx = addr[LINE_SHIFT +: IDX_W];

    // Hit search across all ways, independent of masks.
    assign hit_vec = way_valid & way_match;
    always_comb begin
        hit     = |hit_vec;
        hit_way = '0;
        for (int i = WAYS - 1; i >= 0; i--) if (hit_vec[i]) hit_way = VW'(i);
    end
endmodule

// File: rtl/way_victim_sel_chk.sv
// Property checker for the victim selector, attached by bind.
// Observes ports and the mask selected for the current requester.
module way_victim_sel_chk #(
    parameter int WAYS = 8,
    parameter int VW   = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_we,
    input logic [WAYS-1:0] cfg_mask,
    input logic            cfg_err,
    input logic [WAYS-1:0] sel_mask,
    input logic [WAYS-1:0] way_valid,
    input logic [WAYS-1:0] way_dirty,
    input logic [WAYS-1:0] way_lock,
    input logic [VW-1:0]   victim_way,
    input logic            victim_dirty,
    input logic            no_victim,
    input logic [VW-1:0]   acc_way,
    input logic [WAYS-1:0] use_next
);
    // R3: a refused write raises the error flag one cycle later.
    a_r3_reject_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (&cfg_mask)) |=> cfg_err);

    // R4: the victim is never protected by the requester's mask.
    a_r4_mask_respected: assert property (@(posedge clk) disable iff (!rst_n)
        !no_victim |-> !sel_mask[victim_way]);

    // R5: the victim is never locked.
    a_r5_never_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !no_victim |-> !way_lock[victim_way]);

    // R6: an eligible invalid way takes precedence.
    a_r6_invalid_first: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~way_valid & ~way_lock & ~sel_mask)) |-> !way_valid[victim_way]);

    // R9: no victim only when every way is blocked.
    a_r9_none_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        no_victim |-> (&(way_lock | sel_mask)) && !victim_dirty);

    // R10: a dirty report refers to a valid dirty line.
    a_r10_dirty_real: assert property (@(posedge clk) disable iff (!rst_n)
        victim_dirty |-> (way_valid[victim_way] && way_dirty[victim_way]));

    // R12: the accessed way is always marked used.
    a_r12_acc_marked: assert property (@(posedge clk) disable iff (!rst_n)
        use_next[acc_way]);
endmodule

bind way_victim_sel way_victim_sel_chk #(.WAYS(WAYS), .VW(VW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mask(cfg_mask),
    .cfg_err(cfg_err), .sel_mask(sel_mask), .way_valid(way_valid),
    .way_dirty(way_dirty), .way_lock(way_lock), .victim_way(victim_way),
    .victim_dirty(victim_dirty), .no_victim(no_victim), .acc_way(acc_way),
    .use_next(use_next)
);

// File: tb/way_victim_sel_test.sv
// Directed bench for the victim selector: one task per scenario.
module way_victim_sel_test;
    localparam int WAYS = 8, CORES = 4, SETS = 256, ADDR_W = 32;
    localparam int VW = 3, RID_W = 3, IDX_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [RID_W-1:0]  cfg_sel = '0;
    logic [WAYS-1:0]   cfg_mask = '0;
    logic              cfg_err;
    logic [WAYS-1:0]   mask_rd;
    logic [ADDR_W-1:0] addr = '0;
    logic [IDX_W-1:0]  set_idx;
    logic [RID_W-1:0]  req_id = '0;
    logic [WAYS-1:0]   way_valid = '0, way_dirty = '0, way_lock = '0;
    logic [WAYS-1:0]   way_use = '0, way_match = '0;
    logic [VW-1:0]     victim_way;
    logic              victim_dirty, no_victim, hit;
    logic [VW-1:0]     hit_way;
    logic [VW-1:0]     acc_way = '0;
    logic [WAYS-1:0]   use_next;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    way_victim_sel #(.WAYS(WAYS), .CORES(CORES), .SETS(SETS), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_mask(cfg_mask), .cfg_err(cfg_err), .mask_rd(mask_rd), .addr(addr),
        .set_idx(set_idx), .req_id(req_id), .way_valid(way_valid),
        .way_dirty(way_dirty), .way_lock(way_lock), .way_use(way_use),
        .way_match(way_match), .victim_way(victim_way), .victim_dirty(victim_dirty),
        .no_victim(no_victim), .hit(hit), .hit_way(hit_way), .acc_way(acc_way),
        .use_next(use_next)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive a fill request at the falling edge and let outputs settle.
    task automatic set_req(input logic [RID_W-1:0] id, input logic [WAYS-1:0] v,
                           input logic [WAYS-1:0] d, input logic [WAYS-1:0] l,
                           input logic [WAYS-1:0] u);
        @(negedge clk);
        req_id = id; way_valid = v; way_dirty = d; way_lock = l; way_use = u;
        #2;
    endtask

    // Write one mask; return readback and error flag after the edge.
    task automatic write_mask(input logic [RID_W-1:0] sel, input logic [WAYS-1:0] m,
                              output logic [WAYS-1:0] rd, output logic err);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_mask = m;
        @(posedge clk); #2;
        rd = mask_rd; err = cfg_err;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic t_reset();
        for (int s = 0; s <= CORES; s++) begin
            @(negedge clk); cfg_sel = RID_W'(s); #2;
            chk("R2 reset mask", int'(mask_rd), 0);
        end
        chk("R3 reset err", int'(cfg_err), 0);
    endtask

    task automatic t_index();
        @(negedge clk); addr = 32'h0000_3F80; #2;
        chk("R1 index low", int'(set_idx), 'h7F);
        addr = 32'hFFFF_FF7F; #2;
        chk("R1 index high", int'(set_idx), 'hFE);
    endtask

    task automatic t_masks();
        logic [WAYS-1:0] rd; logic err;
        write_mask(3'd1, 8'hF0, rd, err);
        chk("R2 core1 mask", int'(rd), 'hF0);
        chk("R3 no err on legal", int'(err), 0);
        write_mask(3'd4, 8'h0F, rd, err);
        chk("R2 agent mask", int'(rd), 'h0F);
    endtask

    task automatic t_reject();
        logic [WAYS-1:0] rd; logic err;
        write_mask(3'd1, 8'hFF, rd, err);
        chk("R3 err flag", int'(err), 1);
        chk("R3 mask kept", int'(rd), 'hF0);
        @(posedge clk); #2;
        chk("R3 err one cycle", int'(cfg_err), 0);
    endtask

    task automatic t_priority();
        set_req(3'd1, 8'hFF, 8'h00, 8'h00, 8'h00);
        chk("R7 all cold", int'(victim_way), 0);
        set_req(3'd1, 8'hBB, 8'h00, 8'h00, 8'h00);
        chk("R6 invalid first, masked skipped", int'(victim_way), 2);
        set_req(3'd1, 8'hF6, 8'h00, 8'h01, 8'h00);
        chk("R5 locked invalid skipped", int'(victim_way), 3);
        set_req(3'd1, 8'hFF, 8'h00, 8'h00, 8'h03);
        chk("R7 first clear use", int'(victim_way), 2);
        set_req(3'd1, 8'hFF, 8'h00, 8'h00, 8'hFF);
        chk("R8 all used", int'(victim_way), 0);
        set_req(3'd1, 8'hFF, 8'h00, 8'h01, 8'hFF);
        chk("R8 all used, lock0", int'(victim_way), 1);
        set_req(3'd4, 8'hFF, 8'h00, 8'h00, 8'h00);
        chk("R4 agent mask", int'(victim_way), 4);
        set_req(3'd6, 8'hFF, 8'h00, 8'h00, 8'h00);
        chk("R4 out-of-range id uses agent mask", int'(victim_way), 4);
        set_req(3'd0, 8'hFF, 8'h00, 8'h00, 8'h00);
        chk("R4 core0 unmasked", int'(victim_way), 0);
    endtask

    task automatic t_none();
        set_req(3'd1, 8'hFF, 8'hFF, 8'h0F, 8'h00);
        chk("R9 no_victim", int'(no_victim), 1);
        chk("R9 victim way zero", int'(victim_way), 0);
        chk("R9 no dirty", int'(victim_dirty), 0);
        set_req(3'd1, 8'hFF, 8'hFF, 8'h07, 8'h00);
        chk("R9 one way left", int'(no_victim), 0);
        chk("R5 only unlocked way", int'(victim_way), 3);
    endtask

    task automatic t_dirty();
        set_req(3'd1, 8'hFF, 8'h04, 8'h00, 8'h03);
        chk("R10 dirty victim way", int'(victim_way), 2);
        chk("R10 dirty flag", int'(victim_dirty), 1);
        set_req(3'd1, 8'hFB, 8'h04, 8'h00, 8'h00);
        chk("R10 invalid not dirty", int'(victim_dirty), 0);
        set_req(3'd1, 8'hFF, 8'hFE, 8'h00, 8'h00);
        chk("R10 clean victim", int'(victim_dirty), 0);
    endtask

    task automatic t_hit();
        set_req(3'd1, 8'hFF, 8'h00, 8'h00, 8'h00);
        way_match = 8'h40; #2;
        chk("R11 hit in masked way", int'(hit), 1);
        chk("R11 hit way", int'(hit_way), 6);
        way_valid = 8'hBF; #2;
        chk("R11 invalid no hit", int'(hit), 0);
        way_valid = 8'hFF; way_match = 8'h48; #2;
        chk("R11 lowest hit", int'(hit_way), 3);
        way_match = 8'h00;
    endtask

    task automatic t_use();
        set_req(3'd1, 8'hFF, 8'h00, 8'h00, 8'h05);
        acc_way = 3'd1; #2;
        chk("R12 set no wrap", int'(use_next), 'h07);
        set_req(3'd1, 8'hFF, 8'h00, 8'h00, 8'h07);
        acc_way = 3'd3; #2;
        chk("R12 wrap", int'(use_next), 'h08);
        set_req(3'd1, 8'hFF, 8'h00, 8'h00, 8'hF7);
        acc_way = 3'd3; #2;
        chk("R12 wrap clears masked", int'(use_next), 'h08);
        set_req(3'd1, 8'hFF, 8'h00, 8'h0F, 8'h00);
        acc_way = 3'd2; #2;
        chk("R12 no eligible no wrap", int'(use_next), 'h04);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_index();
        t_masks();
        t_reject();
        t_priority();
        t_none();
        t_dirty();
        t_hit();
        t_use();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule